// File: doc/BRIEF.md
# GF(2) Bit-Matrix Multiplier

This block multiplies two square bit-matrices over GF(2): multiplication is AND and addition is XOR. Each matrix is held as N row words of N bits, and bit j of a row word is column j. A host writes the rows of both operands through a single row-write port, pulses `start`, and after a fixed number of compute cycles receives the N rows of the product on a row-wide output with a valid strobe, in ascending row order.

Inside, each matrix is split into BLK x BLK tiles of TILE x TILE bits. Each tile is packed into one word so that byte r holds tile row r. The operand rows are regrouped into tiles by a byte transpose. For every result tile, the block multiplies the BLK pairs of tiles along the shared index. It then merges the BLK partial tiles through a tree of three-input XOR stages. One block row of the result, TILE result rows, is produced per clock cycle. The default geometry is TILE=8 and BLK=8, which gives a 64x64 matrix computed in 8 cycles.

Top module: `gf2_matmul`

## Requirements
- R1: While `busy` is low, a write with `wr_en` high stores `wr_data` as row `wr_addr` of operand A when `wr_sel` is 0, or of operand B when `wr_sel` is 1. Bit j of a row is column j.
- R2: Streamed row i equals the XOR of every B row j for which bit j of A row i is set, and it is zero when no such bit is set.
- R3: Tiles are packed with byte r as tile row r. A tile times the identity tile yields the same tile. The flipped identity tile (0x0102040810204080 for TILE=8) times a tile reverses the order of that tile's rows. A block-diagonal A made of flipped identity tiles therefore yields result row i equal to B row i XOR 7.
- R4: A `start` sampled while idle raises `busy` at the next edge. The first result row appears with `out_valid` high after exactly BLK further clock edges.
- R5: Results stream over N consecutive cycles with `out_valid` high and `out_row` counting 0 to N-1. After that, `out_valid` and `busy` both return low.
- R6: `busy` stays high from the edge after `start` until the last row has streamed. Row writes presented while `busy` is high leave both operands unchanged.
- R7: A `start` presented while `busy` is high is ignored. The current stream is not disturbed, and no new computation follows it.
- R8: After reset, `busy` and `out_valid` are low and both operands read as all-zero, so a product started with no writes streams zero rows.
- R9: Operands persist across runs. A new `start` with no writes reproduces the previous product, and rewriting one A row changes only the affected result row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Row write strobe |
| wr_sel | input | 1 | Operand select: 0 writes A, 1 writes B |
| wr_addr | input | AW ($clog2(N)) | Row index of the write |
| wr_data | input | N | Row contents; bit j is column j |
| start | input | 1 | Begin a multiplication when idle |
| busy | output | 1 | High during compute and streaming |
| out_valid | output | 1 | High while a result row is presented |
| out_row | output | AW | Index of the presented result row |
| out_data | output | N | Presented result row |

## Verification
The bench builds the block with TILE=8 and BLK=8. At this size the 64-bit flipped identity tile appears exactly as specified. The XOR tree is also uneven at this size: eight partial tiles reduce in groups of three, three and two, then to one. Random, identity, zero, all-ones and flipped-diagonal operands each go through the full eight-cycle compute, and every result row is compared with a row-select XOR model. Directed runs cover writes and `start` pulses made in the middle of a stream, a single-row rewrite between runs, and the cleared operands after reset.

// File: rtl/gf2mm_pkg.sv
`timescale 1ns/1ps
// Package: shared state type and constant helpers for the GF(2) matrix multiplier.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package gf2mm_pkg;

    // Controller phases of the multiplier.
    typedef enum logic [1:0] {
        MM_IDLE    = 2'd0,
        MM_COMPUTE = 2'd1,
        MM_STREAM  = 2'd2
    } mm_state_e;

    // Number of three-input XOR levels needed to fold n operands into one.
    function automatic int xor3_depth(input int n);
        int live;
        int depth;
        live  = n;
        depth = 0;
        while (live > 1) begin
            live  = (live + 2) / 3;
            depth = depth + 1;
        end
        return depth;
    endfunction

endpackage

// File: rtl/gf2_tile_mul.sv
`timescale 1ns/1ps
// Module: gf2_tile_mul
// Multiplies two TILE x TILE bit tiles over GF(2). Each tile is packed so that
// bits [r*TILE +: TILE] hold tile row r and bit c of that row is column c.
// Product row r is the XOR of the rows of b_t selected by the set bits of row r
// of a_t. Purely combinational; assumes nothing about its inputs.
module gf2_tile_mul #(
    parameter  int TILE = 8,
    localparam int TW   = TILE * TILE
) (
    input  logic [TW-1:0] a_t,
    input  logic [TW-1:0] b_t,
    output logic [TW-1:0] p_t
);

    // Identity (flip=0) or anti-diagonal (flip=1) tile.
    function automatic logic [TW-1:0] diag_tile(input bit flip);
        logic [TW-1:0] t;
        t = '0;
        for (int r = 0; r < TILE; r++) begin
            t[r*TILE + (flip ? (TILE - 1 - r) : r)] = 1'b1;
        end
        return t;
    endfunction

    // Tile with its row order reversed.
    function automatic logic [TW-1:0] rev_rows(input logic [TW-1:0] t);
        logic [TW-1:0] o;
        for (int r = 0; r < TILE; r++) begin
            o[r*TILE +: TILE] = t[(TILE-1-r)*TILE +: TILE];
        end
        return o;
    endfunction

    localparam logic [TW-1:0] IDENT_T = diag_tile(1'b0);
    localparam logic [TW-1:0] FLIP_T  = diag_tile(1'b1);

    // Row-select XOR product, then algebraic self-checks on the same values.
    always_comb begin
        for (int r = 0; r < TILE; r++) begin
            logic [TILE-1:0] acc;
            acc = '0;
            for (int k = 0; k < TILE; k++) begin
                if (a_t[r*TILE + k]) acc = acc ^ b_t[k*TILE +: TILE];
            end
            p_t[r*TILE +: TILE] = acc;
        end
        if (b_t == IDENT_T) begin
            p_tile_ident_r3: assert (p_t == a_t);
        end
        if (a_t == FLIP_T) begin
            p_tile_flip_r3: assert (p_t == rev_rows(b_t));
        end
    end

endmodule

// File: rtl/gf2_xor3_tree.sv
`timescale 1ns/1ps
// Module: gf2_xor3_tree
// Folds CNT words of W bits into their XOR through levels of three-input XOR.
// Each level groups neighbours in threes; a short final group passes through.
// Purely combinational.
module gf2_xor3_tree
    import gf2mm_pkg::*;
#(
    parameter int W   = 64,
    parameter int CNT = 8
) (
    input  logic [CNT-1:0][W-1:0] in_vec,
    output logic [W-1:0]          out_sum
);

    localparam int LV = xor3_depth(CNT);

    // Level-by-level reduction in groups of three.
    function automatic logic [W-1:0] reduce3(input logic [CNT-1:0][W-1:0] v);
        logic [CNT-1:0][W-1:0] cur;
        logic [CNT-1:0][W-1:0] nxt;
        int live;
        cur  = v;
        live = CNT;
        for (int l = 0; l < LV; l++) begin
            nxt = '0;
            for (int i = 0; i < CNT; i++) begin
                for (int m = 0; m < 3; m++) begin
                    if (3*i + m < live) nxt[i] = nxt[i] ^ cur[(3*i + m) % CNT];
                end
            end
            cur  = nxt;
            live = (live + 2) / 3;
        end
        return cur[0];
    endfunction

    // Combinational fold of all inputs.
    always_comb begin
        out_sum = reduce3(in_vec);
    end

endmodule

// File: rtl/gf2_blockrow_unit.sv
`timescale 1ns/1ps
// Module: gf2_blockrow_unit
// Computes one block row (TILE result rows) of C = A x B over GF(2).
// a_rows holds the TILE rows of A in that block row, and b_rows holds all of B.
// Rows are regrouped into tiles (byte transpose), BLK x BLK tile products are
// formed, and each result tile is folded by a three-input XOR tree.
// Purely combinational.
module gf2_blockrow_unit #(
    parameter  int TILE = 8,
    parameter  int BLK  = 8,
    localparam int N    = TILE * BLK,
    localparam int TW   = TILE * TILE
) (
    input  logic [TILE-1:0][N-1:0] a_rows,
    input  logic [N-1:0][N-1:0]    b_rows,
    output logic [TILE-1:0][N-1:0] c_rows
);

    logic [BLK-1:0][TILE-1:0][TILE-1:0]          a_tile;  // [k][row][col]
    logic [BLK-1:0][BLK-1:0][TILE-1:0][TILE-1:0] b_tile;  // [k][j][row][col]
    logic [BLK-1:0][BLK-1:0][TW-1:0]             prod;    // [j][k]
    logic [BLK-1:0][TILE-1:0][TILE-1:0]          c_tile;  // [j][row][col]

    for (genvar k = 0; k < BLK; k++) begin : g_k
        for (genvar r = 0; r < TILE; r++) begin : g_ar
            // A tile K of this block row: slice K of each of its rows.
            assign a_tile[k][r] = a_rows[r][k*TILE +: TILE];
        end
        for (genvar j = 0; j < BLK; j++) begin : g_bj
            for (genvar r = 0; r < TILE; r++) begin : g_br
                // B tile (K,J): slice J of the rows in block row K.
                assign b_tile[k][j][r] = b_rows[k*TILE + r][j*TILE +: TILE];
            end
        end
    end

    for (genvar j = 0; j < BLK; j++) begin : g_col
        for (genvar k = 0; k < BLK; k++) begin : g_mul
            gf2_tile_mul #(.TILE(TILE)) u_tile (
                .a_t (a_tile[k]),
                .b_t (b_tile[k][j]),
                .p_t (prod[j][k])
            );
        end
        gf2_xor3_tree #(.W(TW), .CNT(BLK)) u_tree (
            .in_vec  (prod[j]),
            .out_sum (c_tile[j])
        );
        for (genvar r = 0; r < TILE; r++) begin : g_cr
            // Back to row-major: tile J row r lands in slice J of result row r.
            assign c_rows[r][j*TILE +: TILE] = c_tile[j][r];
        end
    end

endmodule

// File: rtl/gf2_matmul.sv
`timescale 1ns/1ps
// Module: gf2_matmul (top)
// Stores two N x N GF(2) operands loaded row by row and, on start, computes
// one block row of the product per cycle for BLK cycles. It then streams the N
// result rows in order with out_valid. Operand writes and start are accepted
// only while idle. Reset is synchronous, active low, and clears all storage.
module gf2_matmul
    import gf2mm_pkg::*;
#(
    parameter  int TILE = 8,
    parameter  int BLK  = 8,
    localparam int N    = TILE * BLK,
    localparam int AW   = $clog2(N),
    localparam int BW   = (BLK > 1) ? $clog2(BLK) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [AW-1:0] wr_addr,
    input  logic [N-1:0]  wr_data,
    input  logic          start,
    output logic          busy,
    output logic          out_valid,
    output logic [AW-1:0] out_row,
    output logic [N-1:0]  out_data
);

    mm_state_e              state;
    logic [BW-1:0]          blk_idx;
    logic [AW-1:0]          row_idx;
    logic [N-1:0][N-1:0]    mat_a;
    logic [N-1:0][N-1:0]    mat_b;
    logic [N-1:0][N-1:0]    mat_c;
    logic [TILE-1:0][N-1:0] a_blk;
    logic [TILE-1:0][N-1:0] c_blk;

    // Operand storage: row writes land only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mat_a <= '0;
            mat_b <= '0;
        end else if (wr_en && state == MM_IDLE) begin
            if (wr_sel) mat_b[wr_addr] <= wr_data;
            else        mat_a[wr_addr] <= wr_data;
        end
    end

    // Rows of A feeding the current block row.
    assign a_blk = mat_a[blk_idx*TILE +: TILE];

    gf2_blockrow_unit #(.TILE(TILE), .BLK(BLK)) u_blockrow (
        .a_rows (a_blk),
        .b_rows (mat_b),
        .c_rows (c_blk)
    );

    // Sequencer: idle -> BLK compute cycles -> N stream cycles -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= MM_IDLE;
            blk_idx <= '0;
            row_idx <= '0;
        end else begin
            case (state)
                MM_IDLE: begin
                    if (start) begin
                        state   <= MM_COMPUTE;
                        blk_idx <= '0;
                    end
                end
                MM_COMPUTE: begin
                    blk_idx <= blk_idx + 1'b1;
                    if (blk_idx == BW'(BLK - 1)) begin
                        state   <= MM_STREAM;
                        row_idx <= '0;
                    end
                end
                MM_STREAM: begin
                    row_idx <= row_idx + 1'b1;
                    if (row_idx == AW'(N - 1)) state <= MM_IDLE;
                end
                default: state <= MM_IDLE;
            endcase
        end
    end

    // Result storage: one block row captured per compute cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mat_c <= '0;
        end else if (state == MM_COMPUTE) begin
            mat_c[blk_idx*TILE +: TILE] <= c_blk;
        end
    end

    // Output view of the sequencer and result storage.
    assign busy      = (state != MM_IDLE);
    assign out_valid = (state == MM_STREAM);
    assign out_row   = row_idx;
    assign out_data  = mat_c[row_idx];

    // R4: an accepted start makes the block busy on the next edge.
    p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R5: each streamed row after the first follows its predecessor.
    p_row_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_row != '0) |-> ($past(out_valid) && out_row == $past(out_row) + 1'b1));

    // R5: the stream ends only after the last row.
    p_stream_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> ($past(out_row) == AW'(N - 1)));

    // R6: writes presented while busy leave both operands untouched.
    p_write_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> ($stable(mat_a) && $stable(mat_b)));

    // R7: start during streaming never restarts the computation.
    p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && start) |=> (state != MM_COMPUTE));

endmodule

// File: tb/gf2_matmul_tb.sv
`timescale 1ns/1ps
// Bench for gf2_matmul: a table of operand patterns walked by one loop,
// then directed runs for reset, persistence, and writes/start while busy.
module gf2_matmul_tb;

    localparam int TILE = 8;
    localparam int BLK  = 8;
    localparam int N    = TILE * BLK;
    localparam int AW   = $clog2(N);

    // Operand pattern codes: 0 zero, 1 identity, 2 random,
    // 3 block-diagonal flipped identity, 4 all ones.
    typedef struct packed {
        logic [2:0]  pat_a;
        logic [2:0]  pat_b;
        logic [63:0] seed;
    } case_t;

    localparam int NCASE = 8;
    localparam case_t CASES [NCASE] = '{
        '{3'd2, 3'd1, 64'h9E37_79B9_7F4A_7C15},
        '{3'd1, 3'd2, 64'h0123_4567_89AB_CDEF},
        '{3'd2, 3'd2, 64'hDEAD_BEEF_CAFE_F00D},
        '{3'd2, 3'd2, 64'h5555_0000_AAAA_1234},
        '{3'd0, 3'd2, 64'h7777_1111_2222_3333},
        '{3'd3, 3'd2, 64'h0BAD_F00D_1357_2468},
        '{3'd4, 3'd2, 64'h1F1F_2E2E_3D3D_4C4C},
        '{3'd2, 3'd4, 64'hC0FF_EE00_0000_0001}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [N-1:0]  wr_data = '0;
    logic          start = 1'b0;
    logic          busy;
    logic          out_valid;
    logic [AW-1:0] out_row;
    logic [N-1:0]  out_data;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    logic [N-1:0] ma   [N];
    logic [N-1:0] mb   [N];
    logic [N-1:0] expv [N];

    always #2.5 clk = ~clk;

    gf2_matmul #(.TILE(TILE), .BLK(BLK)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .start     (start),
        .busy      (busy),
        .out_valid (out_valid),
        .out_row   (out_row),
        .out_data  (out_data)
    );

    task automatic check(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] xs(input logic [63:0] s);
        logic [63:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 7);
        t = t ^ (t << 17);
        return t;
    endfunction

    function automatic logic [N-1:0] pat_row(input int kind, input int i, input logic [63:0] rnd);
        case (kind)
            0:       return '0;
            1:       return N'(1) << i;
            2:       return N'(rnd);
            3:       return N'(1) << (i ^ 7);
            default: return '1;
        endcase
    endfunction

    task automatic fill(input int ka, input int kb, input logic [63:0] seed);
        logic [63:0] st;
        st = seed;
        for (int i = 0; i < N; i++) begin
            st = xs(st);
            ma[i] = pat_row(ka, i, st);
            st = xs(st);
            mb[i] = pat_row(kb, i, st);
        end
    endtask

    // Row-select XOR reference model.
    task automatic build_expect();
        for (int i = 0; i < N; i++) begin
            logic [N-1:0] acc;
            acc = '0;
            for (int j = 0; j < N; j++) begin
                if (ma[i][j]) acc = acc ^ mb[j];
            end
            expv[i] = acc;
        end
    endtask

    task automatic write_row(input bit sel, input int addr, input logic [N-1:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_addr = AW'(addr);
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic load_all();
        for (int i = 0; i < N; i++) write_row(1'b0, i, ma[i]);
        for (int i = 0; i < N; i++) write_row(1'b1, i, mb[i]);
    endtask

    // Start a product and check the whole stream against expv.
    task automatic run_check(input string tag, input bit flip_chk, input bit inject);
        int lat;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy, "R4 busy after start", N'(busy), N'(1));
        lat = 0;
        while (!out_valid && lat < 64) begin
            @(negedge clk);
            lat++;
        end
        check(lat == BLK, "R4 cycles to first row", N'(lat), N'(BLK));
        for (int r = 0; r < N; r++) begin
            check(out_valid && out_row == AW'(r), "R5 row order", N'(out_row), N'(r));
            check(out_data == expv[r], tag, out_data, expv[r]);
            check(busy, "R6 busy while streaming", N'(busy), N'(1));
            if (flip_chk) check(out_data == mb[r ^ 7], "R3 flipped tile row swap", out_data, mb[r ^ 7]);
            if (inject && r == 10) begin
                wr_en   = 1'b1;
                wr_sel  = 1'b0;
                wr_addr = '0;
                wr_data = ~ma[0];
                start   = 1'b1;
            end
            if (inject && r == 11) begin
                wr_en = 1'b0;
                start = 1'b0;
            end
            @(negedge clk);
        end
        check(!out_valid && !busy, "R5 stream ends", {out_valid, busy}, '0);
        if (inject) begin
            bit quiet;
            quiet = 1'b1;
            for (int q = 0; q < 3 * BLK; q++) begin
                if (out_valid || busy) quiet = 1'b0;
                @(negedge clk);
            end
            check(quiet, "R7 no restart after start while busy", N'(quiet), N'(1));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all requirements actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R8: reset state and cleared operands.
        repeat (3) @(negedge clk);
        check(!busy, "R8 busy in reset", N'(busy), '0);
        check(!out_valid, "R8 out_valid in reset", N'(out_valid), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !out_valid, "R8 idle after reset", {busy, out_valid}, '0);
        fill(0, 0, 64'h1);
        build_expect();
        run_check("R8 cleared operands give zero", 1'b0, 1'b0);

        // Table walk: R1 (row port, wr_sel) and R2 (product) on each pattern pair.
        for (int c = 0; c < NCASE; c++) begin
            fill(int'(CASES[c].pat_a), int'(CASES[c].pat_b), CASES[c].seed);
            build_expect();
            load_all();
            run_check("R1 R2 product row", CASES[c].pat_a == 3'd3, 1'b0);
        end

        // R9: operands persist; then a single A row rewrite.
        run_check("R9 rerun without writes", 1'b0, 1'b0);
        ma[5] = 64'hF0F0_1234_8001_0F0F;
        write_row(1'b0, 5, ma[5]);
        build_expect();
        run_check("R9 single row rewrite", 1'b0, 1'b0);

        // R6 and R7: write and start during the stream, then rerun to expose A.
        run_check("R6 product during busy write", 1'b0, 1'b1);
        run_check("R6 busy write left A unchanged", 1'b0, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule